// File: doc/BRIEF.md
# Dispatch Gate with Reorder Buffer

This block sits between a queue of decoded instructions and the out-of-order schedulers. Every cycle the queue shows its oldest `DISP_W` entries, with slot 0 the oldest. The gate picks the longest run of them, starting at slot 0, that fits the machine's free resources. Each instruction states its micro-op count, the number of destinations it renames, and the scheduler it targets. The gate returns how many slots it took, so the queue pops that many. It also returns a reorder-buffer tag for each slot.

The gate keeps three kinds of credit: reorder-buffer entries (one per micro-op), physical registers (one per renamed destination) and the entries of each scheduler buffer. It also owns the reorder buffer itself. Write-back marks an entry complete by its tag. Completed entries then leave from the head, oldest first, up to `RET_W` per cycle. Their entries and registers go back to the pools at that edge. Scheduler entries come back through a per-scheduler release pulse from the issue logic.

Top module: `dispatch_gate`

## Requirements
- R1: Slots are taken strictly in order. Slot 0 is the oldest. Dispatch stops at the first invalid or blocked slot, and no younger slot is taken past it, even if it would fit.
- R2: At most `DISP_W` instructions are dispatched per cycle, and `disp_count` reports how many were taken.
- R3: The micro-op count is 1 to 7. A slot is taken only if the free reorder-buffer entries cover its micro-op count plus the counts of the older slots taken in the same cycle. An exact fit is allowed.
- R4: A slot is taken only if the free physical registers cover its destination count plus those of the older slots taken in the same cycle.
- R5: A slot is taken only if its scheduler has a free entry after the older same-cycle slots bound for it. A `sched_release[k]` pulse returns one entry of scheduler k for the next cycle.
- R6: With `PREG_NUM` = 0 the register pool is unbounded, and destination counts never block dispatch.
- R7: A dispatched instruction's tag is the first reorder-buffer index it occupies. Each following instruction's tag advances by the micro-op count modulo `ROB_DEPTH`.
- R8: A `wb_valid` pulse with a tag marks that entry complete at the clock edge. From the next cycle the entry may retire, but only once every older entry has retired. Up to `RET_W` instructions retire per cycle, reported on `ret_valid`/`ret_tag` in program order, lane 0 oldest.
- R9: The entries and registers of a retiring instruction return at the retire edge and can be used from the following cycle, never before.
- R10: After reset the buffer is empty, all credits are at capacity, and nothing retires.
- R11: No credit count ever goes below zero or above its capacity. After a full drain the whole capacity can be dispatched again in one group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | DISP_W | Slot holds a decoded instruction |
| in_uops | input | DISP_W*3 | Micro-op count per slot |
| in_ndst | input | DISP_W*2 | Destinations to rename per slot |
| in_sched | input | DISP_W*SW | Target scheduler index per slot |
| disp_count | output | DCW | Number of slots taken this cycle |
| disp_tag | output | DISP_W*TW | Reorder-buffer tag per slot |
| sched_release | input | NUM_SCHED | One-entry release per scheduler |
| wb_valid | input | 1 | Write-back completion strobe |
| wb_tag | input | TW | Tag of the completing instruction |
| ret_valid | output | RET_W | Retirement lanes active this cycle |
| ret_tag | output | RET_W*TW | Tags retiring, lane 0 oldest |

## Verification
The bench targets stalls where a younger slot would fit but the older one does not. A gate that let the younger slot bypass would report one taken slot instead of none. It also presents each resource on its own at an exact fit or one short, so a wrong bound appears as an off-by-one group size. Completions arrive out of order, and a design that retired early would present a non-head tag to the scoreboard. The register test probes the retire cycle itself: returning credits at write-back, or one cycle late, flips the dispatch result in a known cycle.

// File: rtl/dg_pkg.sv
package dg_pkg;
    localparam int UOP_W = 3;
    localparam int DST_W = 2;

    typedef struct packed {
        logic             start;
        logic             ready;
        logic [UOP_W-1:0] len;
        logic [DST_W-1:0] nreg;
    } rob_ent_t;
endpackage

// File: rtl/dg_credit.sv
module dg_credit #(
    parameter int CAP = 8,
    parameter int W   = 4,
    parameter int LW  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  alloc,
    input  logic [LW-1:0] give_back,
    output logic [W-1:0]  free
);
    logic [W-1:0] free_q;
    int           nxt;

    always_comb begin
        nxt = int'(free_q) - int'(alloc) + int'(give_back);
        if (nxt > CAP) nxt = CAP;
        if (nxt < 0)   nxt = 0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) free_q <= W'(CAP);
        else        free_q <= W'(nxt);
    end

    assign free = free_q;
endmodule

// File: rtl/dg_select.sv
module dg_select import dg_pkg::*; #(
    parameter int DISP_W    = 2,
    parameter int PREG_NUM  = 16,
    parameter int NUM_SCHED = 2,
    parameter int SW        = 1,
    parameter int CW        = 4,
    parameter int PW        = 5,
    parameter int SCW       = 3
) (
    input  logic [DISP_W-1:0]        in_valid,
    input  logic [DISP_W*UOP_W-1:0]  in_uops,
    input  logic [DISP_W*DST_W-1:0]  in_ndst,
    input  logic [DISP_W*SW-1:0]     in_sched,
    input  logic [CW-1:0]            rob_free,
    input  logic [PW-1:0]            preg_free,
    input  logic [NUM_SCHED*SCW-1:0] sched_free,
    output logic [DISP_W-1:0]        take,
    output logic [DISP_W*CW-1:0]     rob_off,
    output logic [CW-1:0]            rob_alloc,
    output logic [PW-1:0]            preg_alloc,
    output logic [NUM_SCHED*SCW-1:0] sched_alloc
);
    int   ru, pu, u, d, s;
    int   su [NUM_SCHED];
    logic go, r_ok, p_ok, s_ok;

    always_comb begin
        go = 1'b1;
        ru = 0;
        pu = 0;
        u = 0; d = 0; s = 0;
        r_ok = 1'b0; p_ok = 1'b0; s_ok = 1'b0;
        for (int k = 0; k < NUM_SCHED; k++) su[k] = 0;
        take    = '0;
        rob_off = '0;
        for (int i = 0; i < DISP_W; i++) begin
            u = int'(in_uops[i*UOP_W +: UOP_W]);
            d = int'(in_ndst[i*DST_W +: DST_W]);
            s = int'(in_sched[i*SW +: SW]);
            s_ok = 1'b0;
            for (int k = 0; k < NUM_SCHED; k++) begin
                if (k == s && su[k] < int'(sched_free[k*SCW +: SCW])) s_ok = 1'b1;
            end
            r_ok = (ru + u) <= int'(rob_free);
            p_ok = (PREG_NUM == 0) || ((pu + d) <= int'(preg_free));
            if (go && in_valid[i] && r_ok && p_ok && s_ok) begin
                take[i]               = 1'b1;
                rob_off[i*CW +: CW]   = CW'(ru);
                ru                    = ru + u;
                pu                    = pu + d;
                for (int k = 0; k < NUM_SCHED; k++) begin
                    if (k == s) su[k] = su[k] + 1;
                end
            end else begin
                go = 1'b0;
            end
        end
        rob_alloc  = CW'(ru);
        preg_alloc = PW'(pu);
        for (int k = 0; k < NUM_SCHED; k++) sched_alloc[k*SCW +: SCW] = SCW'(su[k]);
    end
endmodule

// File: rtl/dg_rob.sv
module dg_rob import dg_pkg::*; #(
    parameter int DEPTH  = 8,
    parameter int DISP_W = 2,
    parameter int RET_W  = 2,
    parameter int TW     = 3,
    parameter int CW     = 4,
    parameter int PW     = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DISP_W-1:0]        take,
    input  logic [DISP_W*UOP_W-1:0]  in_uops,
    input  logic [DISP_W*DST_W-1:0]  in_ndst,
    input  logic [DISP_W*CW-1:0]     rob_off,
    input  logic [CW-1:0]            alloc,
    input  logic                     wb_valid,
    input  logic [TW-1:0]            wb_tag,
    output logic [TW-1:0]            tail,
    output logic [RET_W-1:0]         ret_valid,
    output logic [RET_W*TW-1:0]      ret_tag,
    output logic [CW-1:0]            ret_ent,
    output logic [PW-1:0]            ret_regs
);
    rob_ent_t      ent [DEPTH];
    logic [TW-1:0] head_q, tail_q, head_d;
    logic [TW-1:0] wr_idx [DISP_W];
    int            ptr, fe, fr;
    logic          go;

    // retirement walk from the head, oldest first
    always_comb begin
        ptr = int'(head_q);
        go  = 1'b1;
        fe  = 0;
        fr  = 0;
        ret_valid = '0;
        ret_tag   = '0;
        for (int r = 0; r < RET_W; r++) begin
            if (go && ent[ptr].start && ent[ptr].ready) begin
                ret_valid[r]           = 1'b1;
                ret_tag[r*TW +: TW]    = TW'(ptr);
                fe                     = fe + int'(ent[ptr].len);
                fr                     = fr + int'(ent[ptr].nreg);
                ptr                    = (ptr + int'(ent[ptr].len)) % DEPTH;
            end else begin
                go = 1'b0;
            end
        end
        head_d   = TW'(ptr);
        ret_ent  = CW'(fe);
        ret_regs = PW'(fr);
    end

    always_comb begin
        for (int i = 0; i < DISP_W; i++)
            wr_idx[i] = TW'((int'(tail_q) + int'(rob_off[i*CW +: CW])) % DEPTH);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            for (int j = 0; j < DEPTH; j++) ent[j] <= '0;
        end else begin
            head_q <= head_d;
            tail_q <= TW'((int'(tail_q) + int'(alloc)) % DEPTH);
            for (int r = 0; r < RET_W; r++) begin
                if (ret_valid[r]) ent[ret_tag[r*TW +: TW]].start <= 1'b0;
            end
            if (wb_valid && ent[wb_tag].start) ent[wb_tag].ready <= 1'b1;
            for (int i = 0; i < DISP_W; i++) begin
                if (take[i]) begin
                    ent[wr_idx[i]] <= rob_ent_t'{start: 1'b1, ready: 1'b0,
                                                 len:  in_uops[i*UOP_W +: UOP_W],
                                                 nreg: in_ndst[i*DST_W +: DST_W]};
                end
            end
        end
    end

    assign tail = tail_q;
endmodule

// File: rtl/dispatch_gate.sv
module dispatch_gate import dg_pkg::*; #(
    parameter int DISP_W      = 2,
    parameter int RET_W       = DISP_W,
    parameter int ROB_DEPTH   = 8,
    parameter int PREG_NUM    = 16,
    parameter int NUM_SCHED   = 2,
    parameter int SCHED_DEPTH = 4,
    localparam int TW  = $clog2(ROB_DEPTH),
    localparam int CW  = $clog2(ROB_DEPTH + 1),
    localparam int PW  = (PREG_NUM > 0) ? $clog2(PREG_NUM + 1) : 1,
    localparam int SW  = (NUM_SCHED > 1) ? $clog2(NUM_SCHED) : 1,
    localparam int SCW = $clog2(SCHED_DEPTH + 1),
    localparam int DCW = $clog2(DISP_W + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DISP_W-1:0]        in_valid,
    input  logic [DISP_W*UOP_W-1:0]  in_uops,
    input  logic [DISP_W*DST_W-1:0]  in_ndst,
    input  logic [DISP_W*SW-1:0]     in_sched,
    output logic [DCW-1:0]           disp_count,
    output logic [DISP_W*TW-1:0]     disp_tag,
    input  logic [NUM_SCHED-1:0]     sched_release,
    input  logic                     wb_valid,
    input  logic [TW-1:0]            wb_tag,
    output logic [RET_W-1:0]         ret_valid,
    output logic [RET_W*TW-1:0]      ret_tag
);
    logic [DISP_W-1:0]        take;
    logic [DISP_W*CW-1:0]     rob_off;
    logic [CW-1:0]            rob_alloc, rob_free, ret_ent;
    logic [PW-1:0]            preg_alloc, preg_free, ret_regs;
    logic [NUM_SCHED*SCW-1:0] sched_alloc, sched_free;
    logic [TW-1:0]            tail;

    dg_select #(
        .DISP_W(DISP_W), .PREG_NUM(PREG_NUM), .NUM_SCHED(NUM_SCHED),
        .SW(SW), .CW(CW), .PW(PW), .SCW(SCW)
    ) u_sel (
        .in_valid(in_valid), .in_uops(in_uops), .in_ndst(in_ndst), .in_sched(in_sched),
        .rob_free(rob_free), .preg_free(preg_free), .sched_free(sched_free),
        .take(take), .rob_off(rob_off), .rob_alloc(rob_alloc),
        .preg_alloc(preg_alloc), .sched_alloc(sched_alloc)
    );

    dg_rob #(
        .DEPTH(ROB_DEPTH), .DISP_W(DISP_W), .RET_W(RET_W), .TW(TW), .CW(CW), .PW(PW)
    ) u_rob (
        .clk(clk), .rst_n(rst_n), .take(take), .in_uops(in_uops), .in_ndst(in_ndst),
        .rob_off(rob_off), .alloc(rob_alloc), .wb_valid(wb_valid), .wb_tag(wb_tag),
        .tail(tail), .ret_valid(ret_valid), .ret_tag(ret_tag),
        .ret_ent(ret_ent), .ret_regs(ret_regs)
    );

    dg_credit #(.CAP(ROB_DEPTH), .W(CW), .LW(CW)) u_rob_cr (
        .clk(clk), .rst_n(rst_n), .alloc(rob_alloc), .give_back(ret_ent), .free(rob_free)
    );

    generate
        if (PREG_NUM > 0) begin : g_preg
            dg_credit #(.CAP(PREG_NUM), .W(PW), .LW(PW)) u_preg_cr (
                .clk(clk), .rst_n(rst_n), .alloc(preg_alloc), .give_back(ret_regs),
                .free(preg_free)
            );
        end else begin : g_unbounded
            assign preg_free = '1;
        end

        for (genvar k = 0; k < NUM_SCHED; k++) begin : g_sch
            dg_credit #(.CAP(SCHED_DEPTH), .W(SCW), .LW(1)) u_sch_cr (
                .clk(clk), .rst_n(rst_n), .alloc(sched_alloc[k*SCW +: SCW]),
                .give_back(sched_release[k]), .free(sched_free[k*SCW +: SCW])
            );
        end

        for (genvar i = 0; i < DISP_W; i++) begin : g_tag
            assign disp_tag[i*TW +: TW] =
                TW'((int'(tail) + int'(rob_off[i*CW +: CW])) % ROB_DEPTH);
        end
    endgenerate

    assign disp_count = DCW'($countones(take));
endmodule

// File: rtl/dg_checker.sv
module dg_checker #(
    parameter int DISP_W    = 2,
    parameter int RET_W     = 2,
    parameter int ROB_DEPTH = 8,
    parameter int PREG_NUM  = 16,
    parameter int DCW       = 2,
    parameter int CW        = 4,
    parameter int PW        = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DISP_W-1:0] in_valid,
    input logic [DCW-1:0]    disp_count,
    input logic [CW-1:0]     rob_free,
    input logic [PW-1:0]     preg_free,
    input logic [RET_W-1:0]  ret_valid
);
    AST_GROUP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        disp_count <= DCW'(DISP_W)); // R2
    AST_HEAD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid[0] |-> disp_count == '0); // R1
    AST_ROB_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        rob_free == '0 |-> disp_count == '0); // R3
    AST_ROB_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        rob_free <= CW'(ROB_DEPTH)); // R11
    AST_ROB_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid[0] && disp_count == '0) |=> rob_free > $past(rob_free)); // R9

    generate
        if (RET_W > 1) begin : g_ret
            AST_RET_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
                ret_valid[1] |-> ret_valid[0]); // R8
        end
        if (PREG_NUM > 0) begin : g_preg
            AST_PREG_CAP: assert property (@(posedge clk) disable iff (!rst_n)
                preg_free <= PW'(PREG_NUM)); // R11
        end
    endgenerate
endmodule

bind dispatch_gate dg_checker #(
    .DISP_W(DISP_W), .RET_W(RET_W), .ROB_DEPTH(ROB_DEPTH), .PREG_NUM(PREG_NUM),
    .DCW(DCW), .CW(CW), .PW(PW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .disp_count(disp_count),
    .rob_free(rob_free), .preg_free(preg_free), .ret_valid(ret_valid)
);

// File: tb/tb_dispatch_gate.sv
module tb_dispatch_gate;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] in_valid = '0;
    logic [5:0] in_uops = '0;
    logic [3:0] in_ndst = '0;
    logic [1:0] in_sched = '0;
    logic [1:0] disp_count;
    logic [5:0] disp_tag;
    logic [1:0] sched_release = '0;
    logic       wb_valid = 1'b0;
    logic [2:0] wb_tag = '0;
    logic [1:0] ret_valid;
    logic [5:0] ret_tag;

    logic [1:0] ub_valid = '0;
    logic [5:0] ub_uops = '0;
    logic [3:0] ub_ndst = '0;
    logic [1:0] ub_sched = '0;
    logic [1:0] ub_count;
    logic [5:0] ub_tag;
    logic [1:0] ub_rv;
    logic [5:0] ub_rt;

    int total = 0;
    int bad = 0;
    int tail = 0;
    int exp_q [$];

    always #5 clk = ~clk;

    dispatch_gate #(.DISP_W(2), .RET_W(2), .ROB_DEPTH(8), .PREG_NUM(6),
                    .NUM_SCHED(2), .SCHED_DEPTH(2)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_uops(in_uops),
        .in_ndst(in_ndst), .in_sched(in_sched), .disp_count(disp_count),
        .disp_tag(disp_tag), .sched_release(sched_release), .wb_valid(wb_valid),
        .wb_tag(wb_tag), .ret_valid(ret_valid), .ret_tag(ret_tag));

    dispatch_gate #(.DISP_W(2), .RET_W(2), .ROB_DEPTH(8), .PREG_NUM(0),
                    .NUM_SCHED(2), .SCHED_DEPTH(4)) dut_ub (
        .clk(clk), .rst_n(rst_n), .in_valid(ub_valid), .in_uops(ub_uops),
        .in_ndst(ub_ndst), .in_sched(ub_sched), .disp_count(ub_count),
        .disp_tag(ub_tag), .sched_release(2'b00), .wb_valid(1'b0),
        .wb_tag(3'd0), .ret_valid(ub_rv), .ret_tag(ub_rt));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver: offer slots, check group size and tags, push expected retire order
    task automatic offer(input int n, input int u0, input int d0, input int s0,
                         input int u1, input int d1, input int s1,
                         input int exp_cnt, input string req);
        int us [2];
        us[0] = u0; us[1] = u1;
        @(negedge clk);
        in_valid = (n >= 2) ? 2'b11 : (n == 1) ? 2'b01 : 2'b00;
        in_uops  = {3'(u1), 3'(u0)};
        in_ndst  = {2'(d1), 2'(d0)};
        in_sched = {1'(s1), 1'(s0)};
        #1;
        chk(int'(disp_count) == exp_cnt, req, int'(disp_count), exp_cnt);
        for (int k = 0; k < exp_cnt; k++) begin
            chk(int'(disp_tag[k*3 +: 3]) == tail, "R7 tag", int'(disp_tag[k*3 +: 3]), tail);
            exp_q.push_back(tail);
            tail = (tail + us[k]) % 8;
        end
        @(posedge clk);
        #1 in_valid = '0;
    endtask

    task automatic wb(input int t);
        @(negedge clk);
        wb_valid = 1'b1;
        wb_tag   = 3'(t);
        @(posedge clk);
        #1 wb_valid = 1'b0;
    endtask

    task automatic rel(input logic [1:0] m);
        @(negedge clk);
        sched_release = m;
        @(posedge clk);
        #1 sched_release = '0;
    endtask

    // monitor: retirements must match dispatch order (R8)
    always @(negedge clk) begin
        if (rst_n) begin
            for (int l = 0; l < 2; l++) begin
                if (ret_valid[l]) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R8 retire with nothing outstanding", int'(ret_tag[l*3 +: 3]), -1);
                    end else begin
                        int e;
                        e = exp_q.pop_front();
                        chk(int'(ret_tag[l*3 +: 3]) == e, "R8 retire order",
                            int'(ret_tag[l*3 +: 3]), e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(disp_count == 2'd0, "R10 idle count", int'(disp_count), 0);
        chk(ret_valid == 2'b00, "R10 no retire", int'(ret_valid), 0);

        // unbounded register pool (R6): 3+3 destinations twice, no stall
        @(negedge clk);
        ub_valid = 2'b11; ub_uops = {3'd1, 3'd1}; ub_ndst = {2'd3, 2'd3}; ub_sched = 2'b10;
        #1 chk(int'(ub_count) == 2, "R6 unbounded pool", int'(ub_count), 2);
        @(negedge clk);
        #1 chk(int'(ub_count) == 2, "R6 unbounded pool again", int'(ub_count), 2);
        @(posedge clk);
        #1 ub_valid = '0;

        offer(2, 1, 1, 0, 1, 1, 1, 2, "R2 full group");
        offer(2, 1, 1, 0, 1, 1, 0, 1, "R5 scheduler full");
        offer(2, 1, 0, 0, 1, 0, 1, 0, "R1 no bypass");
        rel(2'b01);
        offer(2, 4, 0, 1, 2, 0, 0, 1, "R3 rob short");
        offer(1, 1, 2, 0, 0, 0, 0, 1, "R3 exact rob fit");
        rel(2'b11);
        rel(2'b11);

        wb(3);
        chk(ret_valid == 2'b00, "R8 younger waits", int'(ret_valid), 0);
        wb(0);
        chk(ret_valid == 2'b01, "R8 head retires", int'(ret_valid), 1);
        wb(2);
        chk(ret_valid == 2'b00, "R8 gap at head", int'(ret_valid), 0);
        wb(1);
        chk(ret_valid == 2'b11, "R8 two lanes", int'(ret_valid), 3);
        repeat (3) @(posedge clk);

        offer(2, 1, 2, 0, 1, 3, 1, 1, "R4 register short");
        wb(7);
        chk(ret_valid == 2'b01, "R8 tag 7 retires", int'(ret_valid), 1);
        offer(1, 1, 3, 1, 0, 0, 0, 0, "R9 registers not yet back");
        offer(1, 1, 3, 1, 0, 0, 0, 1, "R9 registers back");

        wb(0);
        wb(1);
        repeat (3) @(posedge clk);
        chk(exp_q.size() == 0, "R8 all retired", exp_q.size(), 0);

        rel(2'b11);
        offer(2, 4, 3, 0, 4, 3, 1, 2, "R11 full capacity");
        wb(6);
        wb(2);
        repeat (3) @(posedge clk);
        chk(exp_q.size() == 0, "R11 drained", exp_q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule